// File: doc/BRIEF.md
# Parallel Dispatch and Reorder Unit

This unit sits between a stream of incoming parcels and a shared pool of parallel processing contexts. Each parcel that is accepted goes to the lowest-numbered idle context. It is stamped with a sequence number that counts parcels within its flow group, where the group is a small hashed form of the flow identifier. The unit keeps the flow identifier and the sequence number of every context that is in use. The engines that do the processing are outside the block, and each one can take any number of cycles.

Completions come back tagged only with their context number, and they can arrive in any order. A completion is taken in at once: its context goes back to the idle pool in that cycle, and the result waits in a reorder buffer. For each flow group the unit releases only the entry whose sequence number is the next one that group expects. A released entry goes to a drop/transmit decision input. If the drop is confirmed, the entry is freed. Otherwise it is passed to the enqueue stage when that stage is ready. The unit admits a new parcel only while the contexts in use plus the buffered results leave room in the reorder buffer, so a completion always finds a place to go.

Top module: `dispatch_reorder`

## Requirements
- R1: After reset every context is idle, both sequence tables are zero, the reorder buffer is empty, `inReady` is 1, and `relValid`, `enqValid` and `freeValid` are 0.
- R2: In the cycle that `inValid` and `inReady` are both 1, `dspValid` is 1. In that same cycle `dspCtx` is the lowest-numbered idle context and `dspData` equals `inData`. In any other cycle `dspValid` is 0.
- R3: The flow group is found by XOR folding: bit j of the group is the XOR of every `inFlow` bit i with i mod SLOT_W = j. `dspSeq` is the number of earlier dispatches to the same group, taken modulo 2^SEQ_W, where SEQ_W = clog2(contexts)+1.
- R4: `inReady` is 0 when no context is idle. It is also 0 when the contexts in use plus the occupied reorder entries equal ROB_DEPTH. Otherwise it is 1.
- R5: A completion on `cmpCtx` makes that context idle from the next cycle on. This holds even when the completion's result cannot be released yet.
- R6: Within each flow group, results are released in the order the parcels were dispatched. Each release shows the parcel's original flow as `relFlow`, its sequence number as `relSeq`, and the engine's result as `relData`. Every dispatched parcel is released exactly once.
- R7: While `relValid` is 1, `freeValid` equals `dropDecision` and `enqValid` equals its inverse. Both are 0 while `relValid` is 0.
- R8: A release with `dropDecision`=0 and `enqReady`=0 stays offered and is not lost. It is removed only in a cycle with `dropDecision`=1 or `enqReady`=1.
- R9: A confirmed drop removes the entry without waiting for `enqReady`, which frees buffer room for new dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming parcel present |
| inFlow | input | FLOW_W | Flow identifier of the incoming parcel |
| inData | input | DATA_W | Incoming parcel content |
| inReady | output | 1 | Parcel can be accepted this cycle |
| dspValid | output | 1 | Parcel handed to a context |
| dspCtx | output | CTX_W | Context chosen for the parcel |
| dspSeq | output | SEQ_W | Per-group sequence number given to the parcel |
| dspData | output | DATA_W | Parcel content sent to the engine |
| cmpValid | input | 1 | An engine finished a context |
| cmpCtx | input | CTX_W | Context that finished |
| cmpData | input | DATA_W | Result from the engine |
| relValid | output | 1 | An in-order result is offered |
| relFlow | output | FLOW_W | Flow of the offered result |
| relSeq | output | SEQ_W | Sequence number of the offered result |
| relData | output | DATA_W | Offered result |
| dropDecision | input | 1 | 1 = drop the offered result, 0 = transmit it |
| enqReady | input | 1 | Enqueue stage can take a result |
| enqValid | output | 1 | Offered result is being sent to enqueue |
| freeValid | output | 1 | Offered result is being dropped and freed |

## Verification
On every cycle the assertions check four things: that the context chosen is idle and has no idle context below it, that a completion names a context in use and that this context is idle on the next cycle, that the budget of contexts in use plus buffered entries never goes past the buffer depth, and that the enqueue and drop strobes never fire together. Per-group release order, the sequence values, the hash folding, the holding of a release under backpressure and the recovery of room after drops cannot be seen in any single cycle. The bench shows these with a scoreboard, using directed reverse-latency runs and a long random sweep over all flow identifiers.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Strobes the control side issues to the reorder storage each cycle.
  typedef struct packed {
    logic robWrite;   // take in a completion
    logic robPop;     // retire the current in-order head
  } dr_strobe_t;
endpackage

// File: rtl/dr_ctrl.sv
module dr_ctrl
  import dr_pkg::*;
#(
  parameter int NUM_CTX   = 1600,
  parameter int ROB_DEPTH = 1600,
  parameter int FLOW_W    = 16,
  parameter int SLOT_W    = 6,
  parameter int CTX_W     = 11,
  parameter int SEQ_W     = 12,
  parameter int CNT_W     = 12,
  localparam int NUM_SLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FLOW_W-1:0] inFlow,
  output logic              inReady,
  output logic              dspValid,
  output logic [CTX_W-1:0]  dspCtx,
  output logic [SEQ_W-1:0]  dspSeq,
  input  logic              cmpValid,
  input  logic [CTX_W-1:0]  cmpCtx,
  output logic [FLOW_W-1:0] wrFlow,
  output logic [SLOT_W-1:0] wrSlot,
  output logic [SEQ_W-1:0]  wrSeq,
  input  logic              headValid,
  input  logic [SLOT_W-1:0] headSlot,
  input  logic              dropDecision,
  input  logic              enqReady,
  output logic              enqValid,
  output logic              freeValid,
  output dr_strobe_t        strobe,
  output logic [SEQ_W-1:0]  relSeqTab [NUM_SLOTS],
  output logic [NUM_CTX-1:0] freeMask,
  output logic [CNT_W-1:0]  busyCnt,
  output logic [CNT_W-1:0]  robCnt
);
  logic [FLOW_W-1:0] tagFlow [NUM_CTX];
  logic [SLOT_W-1:0] tagSlot [NUM_CTX];
  logic [SEQ_W-1:0]  tagSeq  [NUM_CTX];
  logic [SEQ_W-1:0]  nextSeq [NUM_SLOTS];
  logic [SLOT_W-1:0] inSlot;
  logic              anyFree;

  // XOR fold of the flow identifier into a group index
  always_comb begin
    inSlot = '0;
    for (int i = 0; i < FLOW_W; i++) inSlot[i % SLOT_W] = inSlot[i % SLOT_W] ^ inFlow[i];
  end

  // lowest idle context
  always_comb begin
    dspCtx = '0;
    for (int c = NUM_CTX - 1; c >= 0; c--) if (freeMask[c]) dspCtx = CTX_W'(c);
  end

  assign anyFree   = |freeMask;
  assign inReady   = anyFree && ((busyCnt + robCnt) < CNT_W'(ROB_DEPTH));
  assign dspValid  = inValid && inReady;
  assign dspSeq    = nextSeq[inSlot];

  assign wrFlow    = tagFlow[cmpCtx];
  assign wrSlot    = tagSlot[cmpCtx];
  assign wrSeq     = tagSeq[cmpCtx];

  assign enqValid  = headValid && !dropDecision;
  assign freeValid = headValid && dropDecision;
  assign strobe.robWrite = cmpValid;
  assign strobe.robPop   = headValid && (dropDecision || enqReady);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      freeMask <= '1;
      busyCnt  <= '0;
      robCnt   <= '0;
      for (int s = 0; s < NUM_SLOTS; s++) begin
        nextSeq[s]   <= '0;
        relSeqTab[s] <= '0;
      end
    end else begin
      if (dspValid) begin
        freeMask[dspCtx] <= 1'b0;
        tagFlow[dspCtx]  <= inFlow;
        tagSlot[dspCtx]  <= inSlot;
        tagSeq[dspCtx]   <= dspSeq;
        nextSeq[inSlot]  <= dspSeq + 1'b1;
      end
      if (cmpValid) freeMask[cmpCtx] <= 1'b1;
      if (strobe.robPop) relSeqTab[headSlot] <= relSeqTab[headSlot] + 1'b1;
      busyCnt <= busyCnt + CNT_W'(dspValid) - CNT_W'(cmpValid);
      robCnt  <= robCnt + CNT_W'(cmpValid) - CNT_W'(strobe.robPop);
    end
  end
endmodule

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_pkg::*;
#(
  parameter int ROB_DEPTH = 1600,
  parameter int FLOW_W    = 16,
  parameter int SLOT_W    = 6,
  parameter int SEQ_W     = 12,
  parameter int DATA_W    = 32,
  localparam int NUM_SLOTS = 1 << SLOT_W,
  localparam int RIDX_W    = $clog2(ROB_DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dr_strobe_t        strobe,
  input  logic [FLOW_W-1:0] wrFlow,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [SEQ_W-1:0]  wrSeq,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEQ_W-1:0]  relSeqTab [NUM_SLOTS],
  output logic              headValid,
  output logic [FLOW_W-1:0] headFlow,
  output logic [SLOT_W-1:0] headSlot,
  output logic [SEQ_W-1:0]  headSeq,
  output logic [DATA_W-1:0] headData,
  output logic [ROB_DEPTH-1:0] robValid
);
  logic [FLOW_W-1:0] eFlow [ROB_DEPTH];
  logic [SLOT_W-1:0] eSlot [ROB_DEPTH];
  logic [SEQ_W-1:0]  eSeq  [ROB_DEPTH];
  logic [DATA_W-1:0] eData [ROB_DEPTH];
  logic [RIDX_W-1:0] wrIdx, headIdx;

  // lowest empty entry receives the next completion
  always_comb begin
    wrIdx = '0;
    for (int e = ROB_DEPTH - 1; e >= 0; e--) if (!robValid[e]) wrIdx = RIDX_W'(e);
  end

  // lowest entry that is the next expected one of its group
  always_comb begin
    headValid = 1'b0;
    headIdx   = '0;
    for (int e = ROB_DEPTH - 1; e >= 0; e--) begin
      if (robValid[e] && (eSeq[e] == relSeqTab[eSlot[e]])) begin
        headValid = 1'b1;
        headIdx   = RIDX_W'(e);
      end
    end
  end

  assign headFlow = eFlow[headIdx];
  assign headSlot = eSlot[headIdx];
  assign headSeq  = eSeq[headIdx];
  assign headData = eData[headIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      robValid <= '0;
    end else begin
      if (strobe.robPop) robValid[headIdx] <= 1'b0;
      if (strobe.robWrite) begin
        robValid[wrIdx] <= 1'b1;
        eFlow[wrIdx]    <= wrFlow;
        eSlot[wrIdx]    <= wrSlot;
        eSeq[wrIdx]     <= wrSeq;
        eData[wrIdx]    <= wrData;
      end
    end
  end
endmodule

// File: rtl/dispatch_reorder.sv
module dispatch_reorder
  import dr_pkg::*;
#(
  parameter int NUM_ENGINES    = 80,
  parameter int CTX_PER_ENGINE = 20,
  parameter int FLOW_W         = 16,
  parameter int SLOT_W         = 6,
  parameter int DATA_W         = 32,
  parameter int ROB_DEPTH      = NUM_ENGINES * CTX_PER_ENGINE,
  localparam int NUM_CTX   = NUM_ENGINES * CTX_PER_ENGINE,
  localparam int CTX_W     = $clog2(NUM_CTX),
  localparam int SEQ_W     = $clog2(NUM_CTX) + 1,
  localparam int CNT_W     = $clog2(ROB_DEPTH + NUM_CTX + 1),
  localparam int NUM_SLOTS = 1 << SLOT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FLOW_W-1:0] inFlow,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              dspValid,
  output logic [CTX_W-1:0]  dspCtx,
  output logic [SEQ_W-1:0]  dspSeq,
  output logic [DATA_W-1:0] dspData,
  input  logic              cmpValid,
  input  logic [CTX_W-1:0]  cmpCtx,
  input  logic [DATA_W-1:0] cmpData,
  output logic              relValid,
  output logic [FLOW_W-1:0] relFlow,
  output logic [SEQ_W-1:0]  relSeq,
  output logic [DATA_W-1:0] relData,
  input  logic              dropDecision,
  input  logic              enqReady,
  output logic              enqValid,
  output logic              freeValid
);
  dr_strobe_t          strobe;
  logic [FLOW_W-1:0]   wrFlow;
  logic [SLOT_W-1:0]   wrSlot, headSlot;
  logic [SEQ_W-1:0]    wrSeq;
  logic [SEQ_W-1:0]    relSeqTab [NUM_SLOTS];
  logic [NUM_CTX-1:0]  freeMask;
  logic [CNT_W-1:0]    busyCnt, robCnt;
  logic [ROB_DEPTH-1:0] robValid;

  assign dspData = inData;

  dr_ctrl #(
    .NUM_CTX(NUM_CTX), .ROB_DEPTH(ROB_DEPTH), .FLOW_W(FLOW_W), .SLOT_W(SLOT_W),
    .CTX_W(CTX_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFlow(inFlow), .inReady(inReady),
    .dspValid(dspValid), .dspCtx(dspCtx), .dspSeq(dspSeq),
    .cmpValid(cmpValid), .cmpCtx(cmpCtx),
    .wrFlow(wrFlow), .wrSlot(wrSlot), .wrSeq(wrSeq),
    .headValid(relValid), .headSlot(headSlot),
    .dropDecision(dropDecision), .enqReady(enqReady),
    .enqValid(enqValid), .freeValid(freeValid), .strobe(strobe),
    .relSeqTab(relSeqTab), .freeMask(freeMask), .busyCnt(busyCnt), .robCnt(robCnt)
  );

  dr_datapath #(
    .ROB_DEPTH(ROB_DEPTH), .FLOW_W(FLOW_W), .SLOT_W(SLOT_W), .SEQ_W(SEQ_W), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrFlow(wrFlow), .wrSlot(wrSlot), .wrSeq(wrSeq), .wrData(cmpData),
    .relSeqTab(relSeqTab),
    .headValid(relValid), .headFlow(relFlow), .headSlot(headSlot),
    .headSeq(relSeq), .headData(relData), .robValid(robValid)
  );
endmodule

// File: rtl/dispatch_reorder_chk.sv
module dispatch_reorder_chk #(
  parameter int NUM_CTX   = 1600,
  parameter int ROB_DEPTH = 1600,
  parameter int CTX_W     = 11,
  parameter int CNT_W     = 12
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 dspValid,
  input logic [CTX_W-1:0]     dspCtx,
  input logic                 cmpValid,
  input logic [CTX_W-1:0]     cmpCtx,
  input logic [NUM_CTX-1:0]   freeMask,
  input logic [CNT_W-1:0]     busyCnt,
  input logic [CNT_W-1:0]     robCnt,
  input logic [ROB_DEPTH-1:0] robValid,
  input logic                 relValid,
  input logic                 enqValid,
  input logic                 freeValid
);
  localparam logic [NUM_CTX-1:0] ONE = NUM_CTX'(1);

  a_r2_pick_idle: assert property (@(posedge clk) disable iff (!rstN)
    dspValid |-> freeMask[dspCtx]);

  a_r2_pick_lowest: assert property (@(posedge clk) disable iff (!rstN)
    dspValid |-> ((freeMask & ((ONE << dspCtx) - ONE)) == '0));

  a_r4_budget: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busyCnt) + int'(robCnt)) <= ROB_DEPTH);

  a_r4_rob_track: assert property (@(posedge clk) disable iff (!rstN)
    int'(robCnt) == $countones(robValid));

  a_r4_busy_track: assert property (@(posedge clk) disable iff (!rstN)
    int'(busyCnt) == NUM_CTX - $countones(freeMask));

  a_r5_cmp_on_busy: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |-> !freeMask[cmpCtx]);

  a_r5_idle_after_cmp: assert property (@(posedge clk) disable iff (!rstN)
    cmpValid |=> freeMask[$past(cmpCtx)]);

  a_r7_one_way: assert property (@(posedge clk) disable iff (!rstN)
    !(enqValid && freeValid));

  a_r7_needs_offer: assert property (@(posedge clk) disable iff (!rstN)
    (enqValid || freeValid) |-> relValid);
endmodule

bind dispatch_reorder dispatch_reorder_chk #(
  .NUM_CTX(NUM_CTX), .ROB_DEPTH(ROB_DEPTH), .CTX_W(CTX_W), .CNT_W(CNT_W)
) uChk (.*);

// File: tb/dispatch_reorder_test.sv
module dispatch_reorder_test;
  localparam int NE = 2, CPE = 2, NCTX = 4, FW = 4, SW = 2, DW = 8, DEPTH = 4;
  localparam int CW = 2, QW = 3, NSLOT = 4, QD = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, cmpValid = 1'b0, dropDecision = 1'b0, enqReady = 1'b0;
  logic [FW-1:0] inFlow = '0;
  logic [DW-1:0] inData = '0, cmpData = '0;
  logic [CW-1:0] cmpCtx = '0;
  logic inReady, dspValid, relValid, enqValid, freeValid;
  logic [CW-1:0] dspCtx;
  logic [QW-1:0] dspSeq, relSeq;
  logic [DW-1:0] dspData, relData;
  logic [FW-1:0] relFlow;

  always #5 clk = ~clk;

  dispatch_reorder #(.NUM_ENGINES(NE), .CTX_PER_ENGINE(CPE), .FLOW_W(FW), .SLOT_W(SW),
                     .DATA_W(DW), .ROB_DEPTH(DEPTH)) uut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // bench model
  bit mBusy [NCTX];
  int mLat [NCTX];
  logic [DW-1:0] mEngData [NCTX];
  int mBusyN = 0, mRobN = 0;
  int dispSeqM [NSLOT], relSeqM [NSLOT];
  logic [FW-1:0] qF [NSLOT][QD];
  logic [DW-1:0] qD [NSLOT][QD];
  int qH [NSLOT], qT [NSLOT];

  // stimulus knobs
  bit wantValid = 0, dropSet = 0, enqSet = 0;
  logic [FW-1:0] wantFlow = '0;
  logic [DW-1:0] wantData = '0;
  int wantLat = 1;

  // per-cycle observations
  int lastCtx = -1, nRel = 0, nFreeSeen = 0, nDisp = 0;
  bit lastDisp = 0, lastRelValid = 0, lastReady = 0;
  int lastRelSeq = 0;

  function automatic int hashF(logic [FW-1:0] f);
    return {f[1] ^ f[3], f[0] ^ f[2]};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    int sel, lowFree, slot;
    bit expReady, took;
    @(negedge clk);
    inValid = wantValid; inFlow = wantFlow; inData = wantData;
    sel = -1;
    for (int c = NCTX - 1; c >= 0; c--) if (mBusy[c] && mLat[c] == 0) sel = c;
    cmpValid = (sel >= 0);
    cmpCtx   = (sel >= 0) ? CW'(sel) : '0;
    cmpData  = (sel >= 0) ? (mEngData[sel] ^ 8'h5A) : '0;
    dropDecision = dropSet; enqReady = enqSet;
    #1;
    lowFree = -1;
    for (int c = NCTX - 1; c >= 0; c--) if (!mBusy[c]) lowFree = c;
    expReady = (lowFree >= 0) && (mBusyN + mRobN < DEPTH);
    took = inValid && expReady;
    check(inReady == expReady, "R4", "inReady", int'(inReady), int'(expReady));
    check(dspValid == took, "R2", "dspValid", int'(dspValid), int'(took));
    lastReady = inReady; lastDisp = dspValid;
    slot = hashF(inFlow);
    if (took) begin
      check(int'(dspCtx) == lowFree, "R2", "dspCtx", int'(dspCtx), lowFree);
      check(dspData == inData, "R2", "dspData", int'(dspData), int'(inData));
      check(int'(dspSeq) == dispSeqM[slot] % 8, "R3", "dspSeq", int'(dspSeq), dispSeqM[slot] % 8);
      lastCtx = int'(dspCtx);
    end
    lastRelValid = relValid; lastRelSeq = int'(relSeq);
    if (relValid) begin
      int rs;
      rs = hashF(relFlow);
      if (qT[rs] == qH[rs]) begin
        check(0, "R6", "release with nothing pending in group", rs, -1);
      end else begin
        check(relFlow == qF[rs][qH[rs] % QD], "R6", "relFlow", int'(relFlow), int'(qF[rs][qH[rs] % QD]));
        check(relData == (qD[rs][qH[rs] % QD] ^ 8'h5A), "R6", "relData", int'(relData),
              int'(qD[rs][qH[rs] % QD] ^ 8'h5A));
        check(int'(relSeq) == relSeqM[rs] % 8, "R6", "relSeq", int'(relSeq), relSeqM[rs] % 8);
      end
      check(enqValid == !dropDecision, "R7", "enqValid", int'(enqValid), int'(!dropDecision));
      check(freeValid == dropDecision, "R7", "freeValid", int'(freeValid), int'(dropDecision));
      if (dropDecision || enqReady) begin
        qH[rs]++; relSeqM[rs]++; mRobN--; nRel++;
        if (dropDecision) nFreeSeen++;
      end
    end else begin
      check(!enqValid && !freeValid, "R7", "strobes without offer", int'({enqValid, freeValid}), 0);
    end
    if (sel >= 0) begin mBusy[sel] = 0; mBusyN--; mRobN++; end
    for (int c = 0; c < NCTX; c++) if (mBusy[c] && mLat[c] > 0) mLat[c]--;
    if (took) begin
      mBusy[lowFree] = 1; mLat[lowFree] = wantLat; mEngData[lowFree] = wantData;
      mBusyN++; nDisp++;
      qF[slot][qT[slot] % QD] = wantFlow; qD[slot][qT[slot] % QD] = wantData; qT[slot]++;
      dispSeqM[slot]++;
    end
  endtask

  task automatic idle(int n);
    wantValid = 0;
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic send(logic [FW-1:0] f, logic [DW-1:0] d, int lat);
    wantValid = 1; wantFlow = f; wantData = d; wantLat = lat;
    cycle();
    wantValid = 0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < NCTX; c++) begin mBusy[c] = 0; mLat[c] = 0; mEngData[c] = '0; end
    for (int s = 0; s < NSLOT; s++) begin dispSeqM[s] = 0; relSeqM[s] = 0; qH[s] = 0; qT[s] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: state right after reset
    check(inReady == 1'b1, "R1", "inReady after reset", int'(inReady), 1);
    check(relValid == 1'b0, "R1", "relValid after reset", int'(relValid), 0);
    check(!enqValid && !freeValid, "R1", "strobes after reset", int'({enqValid, freeValid}), 0);

    // R6/R4/R8: one flow, latencies falling so completions come back reversed
    dropSet = 0; enqSet = 0;
    send(4'd3, 8'h10, 9);
    send(4'd3, 8'h11, 7);
    send(4'd3, 8'h12, 5);
    send(4'd3, 8'h13, 3);
    idle(15);
    check(lastRelValid == 1 && lastRelSeq == 0, "R8", "head held under backpressure",
          lastRelSeq, 0);
    send(4'd9, 8'h20, 2);
    check(lastDisp == 0, "R4", "dispatch with buffer full", int'(lastDisp), 0);
    check(lastRelValid == 1 && lastRelSeq == 0, "R8", "head still held", lastRelSeq, 0);
    enqSet = 1;
    idle(10);
    check(nRel == 4, "R6", "reverse-latency releases", nRel, 4);

    // R5: a context is reusable once its completion is taken, before release
    enqSet = 0;
    send(4'd5, 8'h30, 30);
    send(4'd5, 8'h31, 1);
    idle(2);
    send(4'd6, 8'h32, 2);
    check(lastDisp == 1 && lastCtx == 1, "R5", "context reused after accept", lastCtx, 1);
    enqSet = 1;
    idle(40);
    check(nRel == 7, "R6", "releases after reuse test", nRel, 7);

    // R9: drops retire without enqReady and return room
    dropSet = 1; enqSet = 0;
    for (int k = 0; k < 4; k++) send(FW'(k), DW'(8'h40 + k), 2);
    idle(8);
    check(nFreeSeen == 4, "R9", "drops retired", nFreeSeen, 4);
    check(lastReady == 1, "R9", "room back after drops", int'(lastReady), 1);

    // random sweep over every flow id, latency, decision and backpressure
    for (int i = 0; i < 4000; i++) begin
      wantValid = ($urandom_range(9, 0) < 7);
      wantFlow  = FW'($urandom_range(15, 0));
      wantData  = DW'($urandom_range(255, 0));
      wantLat   = $urandom_range(10, 1);
      dropSet   = ($urandom_range(3, 0) == 0);
      enqSet    = ($urandom_range(9, 0) < 7);
      cycle();
    end
    dropSet = 0; enqSet = 1;
    idle(100);
    begin
      int pend;
      pend = 0;
      for (int s = 0; s < NSLOT; s++) pend += qT[s] - qH[s];
      check(pend == 0, "R6", "results left pending", pend, 0);
    end
    check(nRel == nDisp, "R6", "released count", nRel, nDisp);
    check(mBusyN == 0 && lastReady == 1, "R4", "idle after drain", int'(lastReady), 1);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL R6 watchdog: got %0d expected %0d", 0, 1);
      summary();
    end
  end
endmodule